// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block is the decision engine of a logic-analyzer capture path. Each sample clock it takes a vector of one-bit event flags produced upstream: word, group, channel, transition, range, anything, external signal, glitch and setup/hold detectors, plus the compare flags of two counter/timers. It then evaluates the clauses of its current state. Each state holds a prioritized list of clauses. A clause combines up to eight selected flags with AND or OR. The lowest-numbered true clause fires up to eight actions at once.

The fired actions become registered strobes for the capture logic: a module trigger, a trigger broadcast to all modules, store qualification, counter and timer control, a jump to another state, and set/clear of a small bank of signal bits. A write-only configuration port programs every clause, one field per write. An arm pulse starts a run in state 0 and releases the trigger lock.

Top module: `trig_seq`

## Requirements
- R1: After synchronous active-low reset the block is unarmed, in state 0, with every strobe, every signal bit and the triggered flag at 0. Every clause of every state is disabled, so no event pattern fires anything until clauses are programmed.
- R2: A one-cycle `arm` pulse sets `armed_o` and forces state 0. It also clears `triggered_o` and all signal bits, and it takes precedence over clause evaluation in that cycle. While unarmed, no action fires and state and signals hold.
- R3: A write with `cfg_we` high programs state `cfg_state`, clause `cfg_clause`, field `cfg_field` from `cfg_data`, and the new value governs the following samples. Field 0 is control: bit0 enable, bit1 OR mode (0 selects AND). Fields 1 to 8 are event slots 0 to 7: bit5 slot enable, bits4:0 event index. Fields 9 to 16 are action slots 0 to 7: bits7:4 action code, bits3:0 argument.
- R4: Event bits 0 to 15 are general recognizer flags and bits 16 and 17 are the counter/timer compare flags. A clause in OR mode is true when any enabled slot's flag is 1. In AND mode it is true when all enabled slots' flags are 1. A clause with no enabled slot is never true.
- R5: When several enabled clauses of the current state are true, only the lowest-numbered one fires its actions.
- R6: Action codes are: 0 nothing, 1 trigger this module, 2 trigger all, 3 store, 4 do not store, 5 start store, 6 stop store, 7 increment counter, 8 reset counter, 9 start timer, 10 stop timer, 11 reset timer, 12 go to state, 13 set signal, 14 clear signal. Code 15 does nothing.
- R7: One sample is evaluated every clock. Action strobes appear on the outputs one clock after the sampled events and last exactly one cycle.
- R8: Go-to loads the state given by its argument. If one clause holds several go-to actions, the lowest slot wins. A target at or above the state count is ignored.
- R9: A trigger action raises `trig_o` or `trig_all_o` for one cycle and sets `triggered_o`. After that, trigger actions are suppressed until the next arm, while other actions keep working.
- R10: Set and clear signal actions update the bit indexed by the argument. When one clause both sets and clears the same bit, set wins.
- R11: For counter and timer actions, the argument selects counter/timer 0 or 1. Values at or above the unit count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Start-of-run pulse |
| ev | input | NUM_EVT | Event flags, one per resource |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_state | input | SW | State addressed by the write |
| cfg_clause | input | CW | Clause addressed by the write |
| cfg_field | input | 5 | Field within the clause |
| cfg_data | input | 8 | Field value |
| trig_o | output | 1 | Module trigger pulse |
| trig_all_o | output | 1 | All-module trigger pulse |
| triggered_o | output | 1 | Trigger has occurred this run |
| armed_o | output | 1 | Run in progress |
| store_o | output | 1 | Store this sample |
| nostore_o | output | 1 | Suppress this sample |
| store_start_o | output | 1 | Open store window |
| store_stop_o | output | 1 | Close store window |
| cnt_inc_o | output | NUM_CT | Counter increment strobes |
| cnt_rst_o | output | NUM_CT | Counter reset strobes |
| tmr_start_o | output | NUM_CT | Timer start strobes |
| tmr_stop_o | output | NUM_CT | Timer stop strobes |
| tmr_rst_o | output | NUM_CT | Timer reset strobes |
| state_o | output | SW | Current sequencer state |
| sig_o | output | NUM_SIG | Settable signal bits |

## Verification
The bench drives two true clauses in the same state. A design that scanned clauses from the top, or merged their actions, would change the signal bits where only a store and a jump are expected. It repeats a trigger-carrying clause after a trigger. A missing lock would pulse the trigger twice, and an over-eager lock would also drop the counter reset fired by the same clause. It also covers an AND clause with no slots enabled, where an "all of nothing is true" reduction would fire on an idle sample. Arm is applied together with a live trigger event, where wrong precedence would show a pulse instead of a clean restart. Finally, a runtime disable of the first clause shows that a lower-priority clause takes over.

// File: rtl/tseq_pkg.sv
// Shared constants, action vocabulary and per-clause program record for the
// trigger sequencer. Assumes at most 32 event inputs (5-bit event index).
package tseq_pkg;
    localparam int EV_SLOTS  = 8;
    localparam int ACT_SLOTS = 8;
    localparam int EV_IDX_W  = 5;
    localparam int CODE_W    = 4;
    localparam int ARG_W     = 4;
    localparam int FLD_W     = 5;
    localparam int CFG_DW    = 8;
    localparam int FLD_EV0   = 1;
    localparam int FLD_ACT0  = FLD_EV0 + EV_SLOTS;

    typedef enum logic [CODE_W-1:0] {
        A_NOP       = 4'd0,
        A_TRIG      = 4'd1,
        A_TRIG_ALL  = 4'd2,
        A_STORE     = 4'd3,
        A_NOSTORE   = 4'd4,
        A_STORE_ON  = 4'd5,
        A_STORE_OFF = 4'd6,
        A_CNT_INC   = 4'd7,
        A_CNT_RST   = 4'd8,
        A_TMR_GO    = 4'd9,
        A_TMR_HALT  = 4'd10,
        A_TMR_RST   = 4'd11,
        A_GOTO      = 4'd12,
        A_SIG_SET   = 4'd13,
        A_SIG_CLR   = 4'd14
    } act_e;

    typedef struct packed {
        logic                                en;
        logic                                use_or;
        logic [EV_SLOTS-1:0]                 ev_en;
        logic [EV_SLOTS-1:0][EV_IDX_W-1:0]   ev_idx;
        logic [ACT_SLOTS-1:0][CODE_W-1:0]    act_code;
        logic [ACT_SLOTS-1:0][ARG_W-1:0]     act_arg;
    } clause_t;
endpackage

// File: rtl/tseq_cfg_store.sv
// Clause program table: one record per (state, clause), written one field at a
// time and read out as the full clause list of the current state.
// Assumes writes with out-of-range state or clause are dropped.
module tseq_cfg_store
    import tseq_pkg::*;
#(
    parameter int NUM_STATES  = 16,
    parameter int NUM_CLAUSES = 16,
    parameter int SW          = 4,
    parameter int CW          = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SW-1:0]                    wr_state,
    input  logic [CW-1:0]                    wr_clause,
    input  logic [FLD_W-1:0]                 wr_field,
    input  logic [CFG_DW-1:0]                wr_data,
    input  logic [SW-1:0]                    rd_state,
    output clause_t [NUM_CLAUSES-1:0]        rd_clauses
);
    clause_t tbl [NUM_STATES][NUM_CLAUSES];
    logic    wr_ok;
    int      fld;

    // Qualify the write address against the built table size.
    always_comb begin
        wr_ok = wr_en && (int'(wr_state) < NUM_STATES) && (int'(wr_clause) < NUM_CLAUSES);
        fld   = int'(wr_field);
    end

    // Table update: clear on reset, otherwise patch one field of one clause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STATES; s++)
                for (int c = 0; c < NUM_CLAUSES; c++)
                    tbl[s][c] <= '0;
        end else if (wr_ok) begin
            if (fld == 0) begin
                tbl[wr_state][wr_clause].en     <= wr_data[0];
                tbl[wr_state][wr_clause].use_or <= wr_data[1];
            end
            for (int k = 0; k < EV_SLOTS; k++) begin
                if (fld == FLD_EV0 + k) begin
                    tbl[wr_state][wr_clause].ev_en[k]  <= wr_data[EV_IDX_W];
                    tbl[wr_state][wr_clause].ev_idx[k] <= wr_data[EV_IDX_W-1:0];
                end
            end
            for (int k = 0; k < ACT_SLOTS; k++) begin
                if (fld == FLD_ACT0 + k) begin
                    tbl[wr_state][wr_clause].act_code[k] <= wr_data[CFG_DW-1 -: CODE_W];
                    tbl[wr_state][wr_clause].act_arg[k]  <= wr_data[ARG_W-1:0];
                end
            end
        end
    end

    // Present every clause of the state being evaluated.
    always_comb begin
        for (int c = 0; c < NUM_CLAUSES; c++)
            rd_clauses[c] = tbl[rd_state][c];
    end
endmodule

// File: rtl/tseq_clause_eval.sv
// Evaluates one clause: picks the flagged events named by its slots and
// reduces them with AND or OR. Assumes an empty slot set never matches.
module tseq_clause_eval
    import tseq_pkg::*;
#(
    parameter int NUM_EVT = 18
) (
    input  logic                              en_i,
    input  logic                              or_i,
    input  logic [EV_SLOTS-1:0]               ev_en_i,
    input  logic [EV_SLOTS-1:0][EV_IDX_W-1:0] ev_idx_i,
    input  logic [NUM_EVT-1:0]                ev_i,
    output logic                              hit_o
);
    logic [EV_SLOTS-1:0] picked;
    logic                any_true;
    logic                all_true;

    // Route each slot's chosen event flag; unknown indices read as 0.
    always_comb begin
        picked = '0;
        for (int s = 0; s < EV_SLOTS; s++)
            for (int e = 0; e < NUM_EVT; e++)
                if (ev_idx_i[s] == EV_IDX_W'(e))
                    picked[s] = ev_i[e];
    end

    // Combine the enabled slots in the programmed mode.
    always_comb begin
        any_true = |(ev_en_i & picked);
        all_true = (&(~ev_en_i | picked)) && (|ev_en_i);
        hit_o    = en_i && (or_i ? any_true : all_true);
    end
endmodule

// File: rtl/tseq_prio.sv
// Lowest-index-wins selector over the clause match vector.
module tseq_prio #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    // Scan downward so the lowest requesting index is the last assignment.
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--)
            if (req_i[i])
                idx_o = W'(i);
    end
endmodule

// File: rtl/tseq_act_dec.sv
// Turns the action slots of the firing clause into strobe vectors.
// Assumes the lowest go-to slot wins and out-of-range arguments are dropped.
module tseq_act_dec
    import tseq_pkg::*;
#(
    parameter int NUM_STATES = 16,
    parameter int SW         = 4,
    parameter int NUM_CT     = 2,
    parameter int NUM_SIG    = 4
) (
    input  logic                             fire_i,
    input  logic [ACT_SLOTS-1:0][CODE_W-1:0] code_i,
    input  logic [ACT_SLOTS-1:0][ARG_W-1:0]  arg_i,
    output logic                             trig_o,
    output logic                             trig_all_o,
    output logic                             store_o,
    output logic                             nostore_o,
    output logic                             store_on_o,
    output logic                             store_off_o,
    output logic [NUM_CT-1:0]                cnt_inc_o,
    output logic [NUM_CT-1:0]                cnt_rst_o,
    output logic [NUM_CT-1:0]                tmr_go_o,
    output logic [NUM_CT-1:0]                tmr_halt_o,
    output logic [NUM_CT-1:0]                tmr_rst_o,
    output logic                             goto_vld_o,
    output logic [SW-1:0]                    goto_tgt_o,
    output logic [NUM_SIG-1:0]               sig_set_o,
    output logic [NUM_SIG-1:0]               sig_clr_o
);
    // Decode all slots; descending scan makes slot 0 the final go-to writer.
    always_comb begin
        trig_o = 1'b0; trig_all_o = 1'b0;
        store_o = 1'b0; nostore_o = 1'b0; store_on_o = 1'b0; store_off_o = 1'b0;
        cnt_inc_o = '0; cnt_rst_o = '0; tmr_go_o = '0; tmr_halt_o = '0; tmr_rst_o = '0;
        goto_vld_o = 1'b0; goto_tgt_o = '0;
        sig_set_o = '0; sig_clr_o = '0;
        if (fire_i) begin
            for (int k = ACT_SLOTS - 1; k >= 0; k--) begin
                case (act_e'(code_i[k]))
                    A_TRIG:      trig_o      = 1'b1;
                    A_TRIG_ALL:  trig_all_o  = 1'b1;
                    A_STORE:     store_o     = 1'b1;
                    A_NOSTORE:   nostore_o   = 1'b1;
                    A_STORE_ON:  store_on_o  = 1'b1;
                    A_STORE_OFF: store_off_o = 1'b1;
                    A_CNT_INC:   for (int j = 0; j < NUM_CT; j++) if (arg_i[k] == ARG_W'(j)) cnt_inc_o[j]  = 1'b1;
                    A_CNT_RST:   for (int j = 0; j < NUM_CT; j++) if (arg_i[k] == ARG_W'(j)) cnt_rst_o[j]  = 1'b1;
                    A_TMR_GO:    for (int j = 0; j < NUM_CT; j++) if (arg_i[k] == ARG_W'(j)) tmr_go_o[j]   = 1'b1;
                    A_TMR_HALT:  for (int j = 0; j < NUM_CT; j++) if (arg_i[k] == ARG_W'(j)) tmr_halt_o[j] = 1'b1;
                    A_TMR_RST:   for (int j = 0; j < NUM_CT; j++) if (arg_i[k] == ARG_W'(j)) tmr_rst_o[j]  = 1'b1;
                    A_SIG_SET:   for (int j = 0; j < NUM_SIG; j++) if (arg_i[k] == ARG_W'(j)) sig_set_o[j] = 1'b1;
                    A_SIG_CLR:   for (int j = 0; j < NUM_SIG; j++) if (arg_i[k] == ARG_W'(j)) sig_clr_o[j] = 1'b1;
                    A_GOTO: begin
                        if (int'(arg_i[k]) < NUM_STATES) begin
                            goto_vld_o = 1'b1;
                            goto_tgt_o = SW'(arg_i[k]);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/trig_seq.sv
// Multi-state trigger sequencer top. Each clock it evaluates every clause of
// the current state against the event flags, fires the lowest true clause,
// and registers the resulting strobes, state and signal bits.
// Assumes NUM_STATES <= 16, NUM_SIG <= 16, NUM_CT <= 16 and NUM_EVT <= 32.
module trig_seq
    import tseq_pkg::*;
#(
    parameter int NUM_STATES  = 16,
    parameter int NUM_CLAUSES = 16,
    parameter int NUM_EVT     = 18,
    parameter int NUM_CT      = 2,
    parameter int NUM_SIG     = 4,
    localparam int SW = (NUM_STATES  > 1) ? $clog2(NUM_STATES)  : 1,
    localparam int CW = (NUM_CLAUSES > 1) ? $clog2(NUM_CLAUSES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic [NUM_EVT-1:0]   ev,
    input  logic                 cfg_we,
    input  logic [SW-1:0]        cfg_state,
    input  logic [CW-1:0]        cfg_clause,
    input  logic [FLD_W-1:0]     cfg_field,
    input  logic [CFG_DW-1:0]    cfg_data,
    output logic                 trig_o,
    output logic                 trig_all_o,
    output logic                 triggered_o,
    output logic                 armed_o,
    output logic                 store_o,
    output logic                 nostore_o,
    output logic                 store_start_o,
    output logic                 store_stop_o,
    output logic [NUM_CT-1:0]    cnt_inc_o,
    output logic [NUM_CT-1:0]    cnt_rst_o,
    output logic [NUM_CT-1:0]    tmr_start_o,
    output logic [NUM_CT-1:0]    tmr_stop_o,
    output logic [NUM_CT-1:0]    tmr_rst_o,
    output logic [SW-1:0]        state_o,
    output logic [NUM_SIG-1:0]   sig_o
);
    clause_t [NUM_CLAUSES-1:0] cur_cl;
    logic    [NUM_CLAUSES-1:0] hits;
    logic                      hit_any;
    logic    [CW-1:0]          hit_idx;
    logic                      fire;

    logic                      d_trig, d_trig_all, d_store, d_nostore, d_on, d_off;
    logic    [NUM_CT-1:0]      d_cinc, d_crst, d_tgo, d_thalt, d_trst;
    logic                      d_goto;
    logic    [SW-1:0]          d_tgt;
    logic    [NUM_SIG-1:0]     d_set, d_clr;

    tseq_cfg_store #(
        .NUM_STATES (NUM_STATES),
        .NUM_CLAUSES(NUM_CLAUSES),
        .SW         (SW),
        .CW         (CW)
    ) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_state  (cfg_state),
        .wr_clause (cfg_clause),
        .wr_field  (cfg_field),
        .wr_data   (cfg_data),
        .rd_state  (state_o),
        .rd_clauses(cur_cl)
    );

    for (genvar c = 0; c < NUM_CLAUSES; c++) begin : g_clause
        tseq_clause_eval #(.NUM_EVT(NUM_EVT)) u_eval (
            .en_i    (cur_cl[c].en),
            .or_i    (cur_cl[c].use_or),
            .ev_en_i (cur_cl[c].ev_en),
            .ev_idx_i(cur_cl[c].ev_idx),
            .ev_i    (ev),
            .hit_o   (hits[c])
        );
    end

    tseq_prio #(.N(NUM_CLAUSES), .W(CW)) u_prio (
        .req_i(hits),
        .any_o(hit_any),
        .idx_o(hit_idx)
    );

    // A clause may act only during a run and never in an arm cycle.
    assign fire = armed_o && hit_any && !arm;

    tseq_act_dec #(
        .NUM_STATES(NUM_STATES),
        .SW        (SW),
        .NUM_CT    (NUM_CT),
        .NUM_SIG   (NUM_SIG)
    ) u_dec (
        .fire_i     (fire),
        .code_i     (cur_cl[hit_idx].act_code),
        .arg_i      (cur_cl[hit_idx].act_arg),
        .trig_o     (d_trig),
        .trig_all_o (d_trig_all),
        .store_o    (d_store),
        .nostore_o  (d_nostore),
        .store_on_o (d_on),
        .store_off_o(d_off),
        .cnt_inc_o  (d_cinc),
        .cnt_rst_o  (d_crst),
        .tmr_go_o   (d_tgo),
        .tmr_halt_o (d_thalt),
        .tmr_rst_o  (d_trst),
        .goto_vld_o (d_goto),
        .goto_tgt_o (d_tgt),
        .sig_set_o  (d_set),
        .sig_clr_o  (d_clr)
    );

    // Run control, state, signal bits and registered action strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            armed_o       <= rst_n;
            triggered_o   <= 1'b0;
            state_o       <= '0;
            sig_o         <= '0;
            trig_o        <= 1'b0;
            trig_all_o    <= 1'b0;
            store_o       <= 1'b0;
            nostore_o     <= 1'b0;
            store_start_o <= 1'b0;
            store_stop_o  <= 1'b0;
            cnt_inc_o     <= '0;
            cnt_rst_o     <= '0;
            tmr_start_o   <= '0;
            tmr_stop_o    <= '0;
            tmr_rst_o     <= '0;
        end else begin
            trig_o        <= d_trig && !triggered_o;
            trig_all_o    <= d_trig_all && !triggered_o;
            triggered_o   <= triggered_o | d_trig | d_trig_all;
            store_o       <= d_store;
            nostore_o     <= d_nostore;
            store_start_o <= d_on;
            store_stop_o  <= d_off;
            cnt_inc_o     <= d_cinc;
            cnt_rst_o     <= d_crst;
            tmr_start_o   <= d_tgo;
            tmr_stop_o    <= d_thalt;
            tmr_rst_o     <= d_trst;
            sig_o         <= (sig_o & ~d_clr) | d_set;
            if (d_goto)
                state_o <= d_tgt;
        end
    end
endmodule

// File: rtl/tseq_chk.sv
// Temporal checks on the sequencer's run control, trigger lock and hold
// behaviour; attached to every trig_seq instance by the bind below.
module tseq_chk #(
    parameter int SW      = 4,
    parameter int NUM_SIG = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               arm,
    input logic               armed_o,
    input logic               triggered_o,
    input logic               trig_o,
    input logic               trig_all_o,
    input logic               store_o,
    input logic [SW-1:0]      state_o,
    input logic [NUM_SIG-1:0] sig_o
);
    // R9: a trigger pulse is always accompanied by the triggered flag.
    p_trig_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o || trig_all_o) |-> triggered_o);

    // R9: once triggered and not re-armed, no further trigger pulse.
    p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered_o && !arm) |=> (!trig_o && !trig_all_o));

    // R2: arm restarts the run cleanly.
    p_arm_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (armed_o && !triggered_o && state_o == '0 && sig_o == '0 && !trig_o));

    // R2: an unarmed block produces no strobes.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |=> (!trig_o && !trig_all_o && !store_o));

    // R8: state does not move while unarmed.
    p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !arm) |=> $stable(state_o));

    // R10: signal bits do not move while unarmed.
    p_sig_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !arm) |=> $stable(sig_o));
endmodule

bind trig_seq tseq_chk #(.SW(SW), .NUM_SIG(NUM_SIG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .armed_o    (armed_o),
    .triggered_o(triggered_o),
    .trig_o     (trig_o),
    .trig_all_o (trig_all_o),
    .store_o    (store_o),
    .state_o    (state_o),
    .sig_o      (sig_o)
);

// File: tb/sim_trig_seq.sv
// Scoreboard bench: the driver queues the expected output image of each
// sample, the monitor compares it one clock edge later.
module sim_trig_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [17:0] ev = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_state = '0;
    logic [3:0]  cfg_clause = '0;
    logic [4:0]  cfg_field = '0;
    logic [7:0]  cfg_data = '0;

    logic trig_o, trig_all_o, triggered_o, armed_o;
    logic store_o, nostore_o, store_start_o, store_stop_o;
    logic [1:0] cnt_inc_o, cnt_rst_o, tmr_start_o, tmr_stop_o, tmr_rst_o;
    logic [3:0] state_o, sig_o;

    always #5 clk = ~clk;

    trig_seq u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .ev(ev),
        .cfg_we(cfg_we), .cfg_state(cfg_state), .cfg_clause(cfg_clause),
        .cfg_field(cfg_field), .cfg_data(cfg_data),
        .trig_o(trig_o), .trig_all_o(trig_all_o), .triggered_o(triggered_o),
        .armed_o(armed_o), .store_o(store_o), .nostore_o(nostore_o),
        .store_start_o(store_start_o), .store_stop_o(store_stop_o),
        .cnt_inc_o(cnt_inc_o), .cnt_rst_o(cnt_rst_o), .tmr_start_o(tmr_start_o),
        .tmr_stop_o(tmr_stop_o), .tmr_rst_o(tmr_rst_o),
        .state_o(state_o), .sig_o(sig_o)
    );

    typedef struct packed {
        logic       trig, trall, trd, armd, st, nst, sst, spt;
        logic [1:0] ci, cr, ts, tp, tr;
        logic [3:0] state, sig;
    } obs_t;

    obs_t  got;
    obs_t  exp_q[$];
    string tag_q[$];
    obs_t  mon_e;
    string mon_t;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    assign got = {trig_o, trig_all_o, triggered_o, armed_o, store_o, nostore_o,
                  store_start_o, store_stop_o, cnt_inc_o, cnt_rst_o,
                  tmr_start_o, tmr_stop_o, tmr_rst_o, state_o, sig_o};

    // Monitor: compare each registered result against the queued image.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            checks++;
            if (got !== mon_e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", mon_t, got, mon_e);
            end
        end
    end

    task automatic step(input logic [17:0] e_ev, input logic e_arm, input obs_t e, input string t);
        @(negedge clk);
        cfg_we = 1'b0;
        ev     = e_ev;
        arm    = e_arm;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wr(input int s, input int c, input int f, input logic [7:0] d);
        @(negedge clk);
        ev = '0; arm = 1'b0;
        cfg_we = 1'b1;
        cfg_state = 4'(s); cfg_clause = 4'(c); cfg_field = 5'(f); cfg_data = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ev = '0; arm = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver: program clauses and queue expected output images.
    initial begin
        obs_t e;
        do_reset();

        e = '0;
        step('1, 1'b0, e, "R1 reset idle");
        e = '0; e.armd = 1'b1;
        step('0, 1'b1, e, "R2 arm sets armed");
        step('1, 1'b0, e, "R1 empty tables fire nothing");

        do_reset();
        // state0 clause0: AND(ev3, ev5) -> store, goto1, inc cnt1, goto2
        wr(0, 0, 1, 8'h23); wr(0, 0, 2, 8'h25);
        wr(0, 0, 9, 8'h30); wr(0, 0, 10, 8'hC1); wr(0, 0, 11, 8'h71); wr(0, 0, 12, 8'hC2);
        wr(0, 0, 0, 8'h01);
        // state0 clause1: OR(ev3) -> set sig2
        wr(0, 1, 1, 8'h23); wr(0, 1, 9, 8'hD2); wr(0, 1, 0, 8'h03);
        // state1 clause0: OR(ev16) -> trig, trig all, set0, clr0, clr2, rst cnt0
        wr(1, 0, 1, 8'h30);
        wr(1, 0, 9, 8'h10); wr(1, 0, 10, 8'h20); wr(1, 0, 11, 8'hD0);
        wr(1, 0, 12, 8'hE0); wr(1, 0, 13, 8'hE2); wr(1, 0, 14, 8'h80);
        wr(1, 0, 0, 8'h03);
        // state1 clause1: AND with no slots -> store (must never fire)
        wr(1, 1, 9, 8'h30); wr(1, 1, 0, 8'h01);
        // state1 clause2: OR(ev0) -> start timer0, stop store, no store
        wr(1, 2, 1, 8'h20); wr(1, 2, 9, 8'h90); wr(1, 2, 10, 8'h60); wr(1, 2, 11, 8'h40);
        wr(1, 2, 0, 8'h03);

        e = '0;
        step(18'h00028, 1'b0, e, "R2 unarmed ignores match");
        e = '0; e.armd = 1'b1;
        step('0, 1'b1, e, "R2 arm");
        e = '0; e.armd = 1'b1; e.sig = 4'h4;
        step(18'h00008, 1'b0, e, "R4 AND partial, R3 programmed OR clause, R10 set");
        e = '0; e.armd = 1'b1; e.st = 1'b1; e.ci = 2'b10; e.state = 4'd1; e.sig = 4'h4;
        step(18'h00028, 1'b0, e, "R5 lowest clause, R8 lowest goto, R11 counter1");
        e = '0; e.armd = 1'b1; e.ts = 2'b01; e.spt = 1'b1; e.nst = 1'b1; e.state = 4'd1; e.sig = 4'h4;
        step(18'h00001, 1'b0, e, "R6 action codes, R4 OR mode");
        e = '0; e.armd = 1'b1; e.state = 4'd1; e.sig = 4'h4;
        step('0, 1'b0, e, "R7 one-cycle strobes, R4 empty AND");
        e = '0; e.trig = 1'b1; e.trall = 1'b1; e.trd = 1'b1; e.armd = 1'b1;
        e.cr = 2'b01; e.state = 4'd1; e.sig = 4'h1;
        step(18'h10000, 1'b0, e, "R9 trigger, R10 set wins, R4 counter flag");
        e.trig = 1'b0; e.trall = 1'b0;
        step(18'h10000, 1'b0, e, "R9 trigger locked, other actions run");
        e = '0; e.armd = 1'b1;
        step(18'h10000, 1'b1, e, "R2 arm beats evaluation");
        e = '0; e.armd = 1'b1; e.st = 1'b1; e.ci = 2'b10; e.state = 4'd1;
        step(18'h00028, 1'b0, e, "R8 goto after rearm");
        e = '0; e.trig = 1'b1; e.trall = 1'b1; e.trd = 1'b1; e.armd = 1'b1;
        e.cr = 2'b01; e.state = 4'd1; e.sig = 4'h1;
        step(18'h10000, 1'b0, e, "R9 rearm releases lock");

        wr(1, 0, 0, 8'h00);
        e = '0; e.trd = 1'b1; e.armd = 1'b1; e.state = 4'd1; e.sig = 4'h1;
        step(18'h10000, 1'b0, e, "R3 runtime disable");
        e = '0; e.trd = 1'b1; e.armd = 1'b1; e.ts = 2'b01; e.spt = 1'b1; e.nst = 1'b1;
        e.state = 4'd1; e.sig = 4'h1;
        step(18'h00001, 1'b0, e, "R5 next clause after disable");

        @(negedge clk);
        ev = '0;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule